// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual page number into a physical page number by reading two tables from a word-addressed memory. A request carries a virtual address (page number plus page offset) and the frame number of the root table. The upper index field of the page number selects an entry in the root table. That entry names the frame that holds a second-level table. The lower index field then selects an entry in that second table, and this entry names the final frame.

Each table holds one word per entry and fills exactly one page. The number of entries per table therefore equals the number of words per page. The two index fields and the page offset all share the same width, `IDX_W`. The walker issues at most two reads, one at a time, and each read may take any number of cycles to return. It reports the outcome with a one-cycle `done` pulse. On success it presents the physical address: the final frame number concatenated with the unchanged page offset. Otherwise it raises `fault` and records which level failed.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `done` is 0, `mem_rd_valid` is 0, and `fault`, `fault_lvl` and `rsp_paddr` are 0.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while no walk is in progress. `req_valid` asserted during a walk has no effect on reads or results.
- R3: In the cycle after acceptance, `mem_rd_valid` is high for one cycle. `mem_rd_addr` then equals `{req_root, vaddr[VA_W-1 -: IDX_W]}`: root frame in the high bits, level-1 index in the low `IDX_W` bits.
- R4: At most one read is outstanding. Each `mem_rd_valid` pulse lasts one cycle. No further pulse occurs until `mem_rsp_valid` returns, however many cycles that takes.
- R5: An entry's bit 0 is its valid flag. If the level-1 entry has bit 0 = 0, the next cycle shows `done`=1, `fault`=1, `fault_lvl`=0 and `rsp_paddr`=0, and no second read is issued.
- R6: If the level-1 entry is valid, a second read pulse follows in the cycle after its response. Its address is `{entry[PPN_W:1], level-2 index}`, where the level-2 index is `vaddr[VA_W-IDX_W-1 -: IDX_W]`.
- R7: If the level-2 entry has bit 0 = 0, the cycle after its response shows `done`=1, `fault`=1, `fault_lvl`=1 and `rsp_paddr`=0.
- R8: If the level-2 entry is valid, the cycle after its response shows `done`=1, `fault`=0, `fault_lvl`=1 and `rsp_paddr` = `{entry[PPN_W:1], vaddr[IDX_W-1:0]}`. Entry bits above bit `PPN_W` are ignored.
- R9: `done` is a single-cycle pulse. `fault`, `fault_lvl` and `rsp_paddr` hold their values until the next `done`. `req_ready` is high again in the same cycle as `done`.
- R10: A `mem_rsp_valid` that arrives while no read is outstanding is ignored. It causes no `done`, no read and no change of results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | VA_W (3*IDX_W) | Virtual address: level-1 index, level-2 index, offset |
| req_root | input | PPN_W | Frame number of the root table |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last walk failed |
| fault_lvl | output | 1 | Level of last result (0 = level 1, 1 = level 2) |
| rsp_paddr | output | PA_W (PPN_W+IDX_W) | Physical address of last walk, 0 on fault |
| mem_rd_valid | output | 1 | Read request pulse |
| mem_rd_addr | output | PA_W | Word address of read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Table entry returned |

## Verification
Each result lands a fixed number of edges after the stimulus that causes it:
- The first read pulse appears one cycle after acceptance.
- The second read pulse appears one cycle after the level-1 response.
- `done`, together with its result, appears one cycle after the final response.

The bench has a behavioural model that steps on the same clock edge as the design, using the same input values. Its outputs are compared with the design's ports at every falling edge. Each expected pulse is therefore checked in exactly its due cycle, and a pulse that comes early or late fails in both the cycle where it shows up and the cycle where it should have been. Memory latency is varied from one to five cycles, so the waiting states are exercised at every length in that range.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_LVL1 = 2'd1,
    WK_LVL2 = 2'd2
  } walk_state_t;

  localparam int unsigned NUM_LEVELS = 2;

endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
  parameter int unsigned IDX_W = 4,
  localparam int unsigned VA_W = 3 * IDX_W
) (
  input  logic [VA_W-1:0]  vaddr,
  output logic [IDX_W-1:0] idx_l1,
  output logic [IDX_W-1:0] idx_l2,
  output logic [IDX_W-1:0] page_off
);

  // layout: {level-1 index, level-2 index, page offset}
  assign idx_l1   = vaddr[VA_W-1 -: IDX_W];
  assign idx_l2   = vaddr[VA_W-IDX_W-1 -: IDX_W];
  assign page_off = vaddr[IDX_W-1:0];

endmodule

// File: rtl/ptw_addr_form.sv
module ptw_addr_form #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned PPN_W = 8,
  localparam int unsigned PA_W = PPN_W + IDX_W
) (
  input  logic [PPN_W-1:0] table_frame,
  input  logic [IDX_W-1:0] entry_idx,
  output logic [PA_W-1:0]  word_addr
);

  // one table fills one page, so the entry index is the in-page word offset
  assign word_addr = {table_frame, entry_idx};

endmodule

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk #(
  parameter int unsigned PPN_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] entry,
  output logic              present,
  output logic [PPN_W-1:0]  frame
);

  assign present = entry[0];
  assign frame   = entry[PPN_W:1];

  generate
    if (DATA_W > PPN_W + 1) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^entry[DATA_W-1:PPN_W+1];
    end
  endgenerate

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import pt_walker_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned PPN_W  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PA_W  = PPN_W + IDX_W,
  localparam int unsigned KEEP_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_idx_l2,
  input  logic [IDX_W-1:0]  req_off,
  output logic [IDX_W-1:0]  held_idx_l2,
  input  logic [PA_W-1:0]   addr_l1,
  input  logic [PA_W-1:0]   addr_l2,
  input  logic              ent_present,
  input  logic [PPN_W-1:0]  ent_frame,
  input  logic              mem_rsp_valid,
  output logic              mem_rd_valid,
  output logic [PA_W-1:0]   mem_rd_addr,
  output logic              done,
  output logic              fault,
  output logic              fault_lvl,
  output logic [PA_W-1:0]   rsp_paddr
);

  walk_state_t       state_q, state_d;
  logic [KEEP_W-1:0] keep_q;
  logic              rd_v_q, rd_v_d;
  logic [PA_W-1:0]   rd_a_q, rd_a_d;
  logic              done_q, done_d;
  logic              flt_q, flt_d;
  logic              lvl_q, lvl_d;
  logic [PA_W-1:0]   pa_q, pa_d;
  logic              accept;

  assign accept      = req_valid && (state_q == WK_IDLE);
  assign held_idx_l2 = keep_q[KEEP_W-1 -: IDX_W];

  always_comb begin
    state_d = state_q;
    rd_v_d  = 1'b0;
    rd_a_d  = rd_a_q;
    done_d  = 1'b0;
    flt_d   = flt_q;
    lvl_d   = lvl_q;
    pa_d    = pa_q;
    unique case (state_q)
      WK_IDLE: begin
        if (req_valid) begin
          state_d = WK_LVL1;
          rd_v_d  = 1'b1;
          rd_a_d  = addr_l1;
        end
      end
      WK_LVL1: begin
        if (mem_rsp_valid) begin
          if (!ent_present) begin
            state_d = WK_IDLE;
            done_d  = 1'b1;
            flt_d   = 1'b1;
            lvl_d   = 1'b0;
            pa_d    = '0;
          end else begin
            state_d = WK_LVL2;
            rd_v_d  = 1'b1;
            rd_a_d  = addr_l2;
          end
        end
      end
      WK_LVL2: begin
        if (mem_rsp_valid) begin
          state_d = WK_IDLE;
          done_d  = 1'b1;
          lvl_d   = 1'b1;
          flt_d   = !ent_present;
          pa_d    = ent_present ? {ent_frame, keep_q[IDX_W-1:0]} : '0;
        end
      end
      default: state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      keep_q  <= '0;
      rd_v_q  <= 1'b0;
      rd_a_q  <= '0;
      done_q  <= 1'b0;
      flt_q   <= 1'b0;
      lvl_q   <= 1'b0;
      pa_q    <= '0;
    end else begin
      state_q <= state_d;
      rd_v_q  <= rd_v_d;
      done_q  <= done_d;
      if (accept) begin
        keep_q <= {req_idx_l2, req_off};
      end
      if (rd_v_d) begin
        rd_a_q <= rd_a_d;
      end
      if (done_d) begin
        flt_q <= flt_d;
        lvl_q <= lvl_d;
        pa_q  <= pa_d;
      end
    end
  end

  assign req_ready    = (state_q == WK_IDLE);
  assign mem_rd_valid = rd_v_q;
  assign mem_rd_addr  = rd_a_q;
  assign done         = done_q;
  assign fault        = flt_q;
  assign fault_lvl    = lvl_q;
  assign rsp_paddr    = pa_q;

  // R3
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_rd_valid && mem_rd_addr == $past(addr_l1)));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |=> !mem_rd_valid);

  // R4
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !mem_rsp_valid) |=> !mem_rd_valid);

  // R5
  l1_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WK_LVL1 && mem_rsp_valid && !ent_present)
      |=> (done && fault && !fault_lvl && !mem_rd_valid));

  // R6
  second_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WK_LVL1 && mem_rsp_valid && ent_present)
      |=> (mem_rd_valid && mem_rd_addr == {$past(ent_frame), held_idx_l2}));

  // R8
  walk_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WK_LVL2 && mem_rsp_valid && ent_present)
      |=> (done && !fault && fault_lvl && rsp_paddr[PA_W-1 -: PPN_W] == $past(ent_frame)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rsp_paddr) && $stable(fault) && $stable(fault_lvl)));

  // R10
  stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && mem_rsp_valid && !req_valid) |=> (!done && !mem_rd_valid && req_ready));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned PPN_W  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned VA_W  = 3 * IDX_W,
  localparam int unsigned PA_W  = PPN_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PPN_W-1:0]  req_root,
  output logic              done,
  output logic              fault,
  output logic              fault_lvl,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              mem_rd_valid,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  logic [IDX_W-1:0] va_l1, va_l2, va_off, held_l2;
  logic             ent_present;
  logic [PPN_W-1:0] ent_frame;
  logic [PPN_W-1:0] lvl_base [NUM_LEVELS];
  logic [IDX_W-1:0] lvl_idx  [NUM_LEVELS];
  logic [PA_W-1:0]  lvl_addr [NUM_LEVELS];

  ptw_va_split #(.IDX_W(IDX_W)) u_split (
    .vaddr    (req_vaddr),
    .idx_l1   (va_l1),
    .idx_l2   (va_l2),
    .page_off (va_off)
  );

  ptw_entry_chk #(.PPN_W(PPN_W), .DATA_W(DATA_W)) u_entry (
    .entry   (mem_rsp_data),
    .present (ent_present),
    .frame   (ent_frame)
  );

  for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_lvl
    if (lv == 0) begin : g_root
      assign lvl_base[lv] = req_root;
      assign lvl_idx[lv]  = va_l1;
    end else begin : g_leaf
      assign lvl_base[lv] = ent_frame;
      assign lvl_idx[lv]  = held_l2;
    end
    ptw_addr_form #(.IDX_W(IDX_W), .PPN_W(PPN_W)) u_addr (
      .table_frame (lvl_base[lv]),
      .entry_idx   (lvl_idx[lv]),
      .word_addr   (lvl_addr[lv])
    );
  end

  ptw_ctrl #(.IDX_W(IDX_W), .PPN_W(PPN_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_idx_l2    (va_l2),
    .req_off       (va_off),
    .held_idx_l2   (held_l2),
    .addr_l1       (lvl_addr[0]),
    .addr_l2       (lvl_addr[1]),
    .ent_present   (ent_present),
    .ent_frame     (ent_frame),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_addr   (mem_rd_addr),
    .done          (done),
    .fault         (fault),
    .fault_lvl     (fault_lvl),
    .rsp_paddr     (rsp_paddr)
  );

  // R2
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  l1_fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault_lvl) |-> (fault && rsp_paddr == '0));

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  localparam int IDX_W  = 4;
  localparam int PPN_W  = 8;
  localparam int DATA_W = 32;
  localparam int VA_W   = 3 * IDX_W;
  localparam int PA_W   = PPN_W + IDX_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [VA_W-1:0]   req_vaddr;
  logic [PPN_W-1:0]  req_root;
  logic              done, fault, fault_lvl;
  logic [PA_W-1:0]   rsp_paddr;
  logic              mem_rd_valid;
  logic [PA_W-1:0]   mem_rd_addr;
  logic              mem_rsp_valid;
  logic [DATA_W-1:0] mem_rsp_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pt_walker #(.IDX_W(IDX_W), .PPN_W(PPN_W), .DATA_W(DATA_W)) u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_root,
    .done, .fault, .fault_lvl, .rsp_paddr,
    .mem_rd_valid, .mem_rd_addr, .mem_rsp_valid, .mem_rsp_data
  );

  // ---------------- table memory and responder ----------------
  logic [DATA_W-1:0] tbl [int];
  int  lat_cfg   = 1;
  bit  stray_req = 1'b0;
  int  pend_cnt  = 0;
  int  pend_addr = 0;

  function automatic logic [DATA_W-1:0] rd_word(input int a);
    return tbl.exists(a) ? tbl[a] : '0;
  endfunction

  function automatic int waddr(input int frame, input int idx);
    return frame * (1 << IDX_W) + idx;
  endfunction

  function automatic logic [DATA_W-1:0] mk_ent(input int frame, input bit v, input bit junk);
    return (junk ? 32'hA500_0000 : 32'h0) | (DATA_W'(frame) << 1) | DATA_W'(v);
  endfunction

  always @(posedge clk) begin
    #1;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    if (pend_cnt > 0) begin
      pend_cnt = pend_cnt - 1;
      if (pend_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd_word(pend_addr);
      end
    end
    if (stray_req) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mk_ent(8'h33, 1'b1, 1'b0);
    end
    if (rst_n && mem_rd_valid) begin
      pend_cnt  = lat_cfg;
      pend_addr = int'(mem_rd_addr);
      lat_cfg   = (lat_cfg % 5) + 1;
    end
  end

  // ---------------- behavioural reference ----------------
  int              m_phase;
  logic [VA_W-1:0] m_va;
  bit              m_rd;
  logic [PA_W-1:0] m_addr;
  bit              m_done, m_fault, m_lvl;
  logic [PA_W-1:0] m_pa;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_va = '0; m_rd = 0; m_addr = '0;
      m_done = 0; m_fault = 0; m_lvl = 0; m_pa = '0;
    end else begin
      automatic bit rv = req_valid;
      automatic bit sv = mem_rsp_valid;
      automatic logic [DATA_W-1:0] d = mem_rsp_data;
      m_rd = 0; m_done = 0;
      if (m_phase == 0) begin
        if (rv) begin
          m_va    = req_vaddr;
          m_addr  = PA_W'(waddr(int'(req_root), int'(req_vaddr) >> (2 * IDX_W)));
          m_rd    = 1;
          m_phase = 1;
        end
      end else if (m_phase == 1) begin
        if (sv) begin
          if (d[0] == 1'b0) begin
            m_done = 1; m_fault = 1; m_lvl = 0; m_pa = '0; m_phase = 0;
          end else begin
            m_addr  = PA_W'(waddr(int'(d[PPN_W:1]), (int'(m_va) >> IDX_W) % (1 << IDX_W)));
            m_rd    = 1;
            m_phase = 2;
          end
        end
      end else begin
        if (sv) begin
          m_done = 1; m_lvl = 1; m_fault = !d[0];
          m_pa   = d[0] ? PA_W'(waddr(int'(d[PPN_W:1]), int'(m_va) % (1 << IDX_W))) : '0;
          m_phase = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  bit cmp_en = 1'b0;
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk(req_ready == (m_phase == 0), "R2", "req_ready", 32'(req_ready), 32'(m_phase == 0));
      chk(mem_rd_valid == m_rd, "R4", "mem_rd_valid", 32'(mem_rd_valid), 32'(m_rd));
      if (m_rd)
        chk(mem_rd_addr == m_addr, (m_phase == 1) ? "R3" : "R6", "mem_rd_addr",
            32'(mem_rd_addr), 32'(m_addr));
      chk(done == m_done, "R9", "done", 32'(done), 32'(m_done));
      chk(fault == m_fault, m_lvl ? "R7" : "R5", "fault", 32'(fault), 32'(m_fault));
      chk(fault_lvl == m_lvl, m_lvl ? "R7" : "R5", "fault_lvl", 32'(fault_lvl), 32'(m_lvl));
      chk(rsp_paddr == m_pa, "R8", "rsp_paddr", 32'(rsp_paddr), 32'(m_pa));
    end
  end

  task automatic walk(input logic [VA_W-1:0] va, input logic [PPN_W-1:0] root);
    @(posedge clk); #2;
    req_valid = 1'b1; req_vaddr = va; req_root = root;
    @(posedge clk); #2;
    req_valid = 1'b0;
    repeat (20) @(posedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_root = '0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;

    // root table in frame 0x10, second root in frame 0x20
    tbl[waddr(8'h10, 3)]  = mk_ent(8'h40, 1'b1, 1'b0);
    tbl[waddr(8'h40, 7)]  = mk_ent(8'h9C, 1'b1, 1'b0);
    tbl[waddr(8'h40, 2)]  = mk_ent(8'h11, 1'b0, 1'b0);   // invalid leaf
    tbl[waddr(8'h10, 5)]  = mk_ent(8'h55, 1'b0, 1'b1);   // missing level-2 table
    tbl[waddr(8'h10, 15)] = mk_ent(8'hFF, 1'b1, 1'b1);
    tbl[waddr(8'hFF, 15)] = mk_ent(8'hFF, 1'b1, 1'b1);
    tbl[waddr(8'h20, 3)]  = mk_ent(8'h41, 1'b1, 1'b0);
    tbl[waddr(8'h41, 7)]  = mk_ent(8'h01, 1'b1, 1'b0);

    repeat (3) @(posedge clk);
    #3;
    // R1: reset values
    chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'd1);
    chk(done == 1'b0 && mem_rd_valid == 1'b0, "R1", "done/rd", 32'({done, mem_rd_valid}), 32'd0);
    chk(rsp_paddr == '0 && fault == 1'b0 && fault_lvl == 1'b0, "R1", "results",
        32'(rsp_paddr), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #3;
    chk(req_ready == 1'b1 && done == 1'b0 && mem_rd_valid == 1'b0, "R1", "after release",
        32'({req_ready, done, mem_rd_valid}), 32'b100);
    cmp_en = 1'b1;

    // R8: successful walk
    walk({4'd3, 4'd7, 4'hA}, 8'h10);
    // R5: level-1 entry not present, no second read
    walk({4'd5, 4'd7, 4'h1}, 8'h10);
    // R7: level-2 entry not present
    walk({4'd3, 4'd2, 4'h6}, 8'h10);
    // R8 with extreme indices, frame and junk high bits
    walk({4'd15, 4'd15, 4'hF}, 8'h10);
    // R3: different root frame
    walk({4'd3, 4'd7, 4'h0}, 8'h20);
    // R5: untouched root entry reads as zero
    walk({4'd0, 4'd0, 4'h0}, 8'h7E);

    // R2: request held high gives back-to-back walks; re-accepted right after done
    @(posedge clk); #2;
    req_valid = 1'b1; req_vaddr = {4'd3, 4'd7, 4'h5}; req_root = 8'h10;
    repeat (30) @(posedge clk);
    #2 req_valid = 1'b0;
    repeat (20) @(posedge clk);

    // R2: new request pulsed during a walk is ignored
    @(posedge clk); #2;
    req_valid = 1'b1; req_vaddr = {4'd3, 4'd7, 4'h2}; req_root = 8'h10;
    @(posedge clk); #2;
    req_vaddr = {4'd5, 4'd0, 4'h0};
    @(posedge clk); #2;
    req_vaddr = {4'd0, 4'd0, 4'h0}; req_root = 8'h20;
    @(posedge clk); #2;
    req_valid = 1'b0;
    repeat (20) @(posedge clk);

    // R10: stray response while idle
    @(posedge clk); #0;
    stray_req = 1'b1;
    @(posedge clk); #2;
    stray_req = 1'b0;
    @(posedge clk); #3;
    chk(mem_rd_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R10", "stray ignored",
        32'({mem_rd_valid, done, req_ready}), 32'b001);
    repeat (5) @(posedge clk);
    walk({4'd3, 4'd7, 4'h9}, 8'h10);

    cmp_en = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule